// File: doc/BRIEF.md
# Interrupt Processor-Routing Register Bank

This block keeps the processor routing for every interrupt of an interrupt distributor. Each interrupt owns one byte in a memory-mapped window. Each bit of that byte selects one processor that the interrupt is delivered to. Interrupt n sits at byte offset n of the window, which is byte lane n mod 4 of word n/4. The window starts at distributor offset 0x800 and spans 0x800 to 0xBFF.

Software reaches the bank over a plain register bus. A transfer carries an address, write data, a write strobe with four byte enables, and a read strobe with four byte enables. Single-byte and whole-word transfers both work, because the enables pick the lanes and the two low address bits are ignored.

Two parameters set the size of the bank. `NUM_CPUS` is the number of implemented processors, from 1 to 8. `NUM_IRQS` is the number of implemented interrupts, a multiple of 32 and at most 1020. Processor bits above `NUM_CPUS` always read as zero and ignore writes. Byte offsets at or above `NUM_IRQS` also read as zero and ignore writes. The bus has no back-pressure: the bank accepts every transfer in the cycle it is presented.

Top module: `irq_tgt_bank`

## Requirements
- R1: After reset every routing byte of every implemented interrupt reads as zero.
- R2: A word write with all four write enables stores the data so that interrupt n's byte sits in lane n mod 4 of word n/4. A word read then returns it. With four processors, 0x0103020F reads back as 0x0103020F.
- R3: Bits for processors at index `NUM_CPUS` or higher read as zero in every lane and ignore writes. With four processors, writing 0xFFFFFFFF reads back as 0x0F0F0F0F.
- R4: A write updates only the lanes whose write enable is set. The other bytes of the word keep their previous contents.
- R5: Lanes whose read enable is clear return zero. A single-byte read returns the addressed interrupt's byte in its own lane.
- R6: Byte offsets within the window that are at or above `NUM_IRQS` read as zero, ignore writes, and never alias onto implemented words.
- R7: Addresses outside the window 0x800 to 0xBFF read as zero and ignore writes.
- R8: Read data appears in the cycle right after the read strobe is sampled. In any cycle that does not follow a sampled read, the read data is zero.
- R9: When a read and a write hit the same word in one cycle, the read returns the contents from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address within the distributor space |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, one byte per lane |
| bus_wstrb | input | 4 | Write enables, one per byte lane |
| bus_rd | input | 1 | Read strobe |
| bus_rstrb | input | 4 | Read enables, one per byte lane |
| bus_rdata | output | 32 | Registered read data |

## Verification
A write takes effect at the rising edge where its strobe is sampled. It is visible to any read whose strobe is sampled at a later edge. Read data is registered, so it is due one edge after the read strobe is sampled. The bench drives each transfer on a falling edge, lets one rising edge pass, and compares on the next falling edge. It also checks on the falling edge after that, where the data must have returned to zero. For the same-cycle read and write case, the expected value is taken from the bench model before the write is applied to the model.

// File: rtl/irq_tgt_pkg.sv
`timescale 1ns/1ps
package irq_tgt_pkg;
  localparam int LANES = 4;

  // spread one enable per byte lane into a 32-bit mask
  function automatic logic [31:0] lane_mask(input logic [LANES-1:0] en);
    logic [31:0] m;
    for (int l = 0; l < LANES; l++) m[8*l +: 8] = {8{en[l]}};
    return m;
  endfunction

  // low bits set for each implemented processor
  function automatic logic [7:0] cpu_byte(input int n);
    return 8'((1 << n) - 1);
  endfunction

  function automatic logic [31:0] cpu_word(input int n);
    return {4{cpu_byte(n)}};
  endfunction
endpackage

// File: rtl/irq_tgt_decode.sv
`timescale 1ns/1ps
module irq_tgt_decode #(
  parameter int                ADDR_W   = 12,
  parameter int                SPAN_W   = 10,
  parameter logic [ADDR_W-1:0] BASE     = 12'h800,
  parameter int                NUM_IRQS = 64,
  parameter int                IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic             in_win;
  logic [SPAN_W-1:0] ofs;

  assign in_win = (addr[ADDR_W-1:SPAN_W] == BASE[ADDR_W-1:SPAN_W]);
  assign ofs    = addr[SPAN_W-1:0];
  // byte offset compare: covers every interrupt slot past the last one
  assign hit    = in_win && (int'(ofs) < NUM_IRQS);
  assign idx    = ofs[2 +: IDX_W];
endmodule

// File: rtl/irq_tgt_store.sv
`timescale 1ns/1ps
module irq_tgt_store
  import irq_tgt_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_WORDS = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wstrb,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      word
);
  localparam logic [7:0] CPU_M = cpu_byte(NUM_CPUS);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [NUM_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < NUM_WORDS; w++) mem[w] <= '0;
      end else if (wr_en && wstrb[l]) begin
        mem[idx] <= wdata[8*l +: 8] & CPU_M;
      end
    end

    assign word[8*l +: 8] = mem[idx];
  end
endmodule

// File: rtl/irq_tgt_rdport.sv
`timescale 1ns/1ps
module irq_tgt_rdport
  import irq_tgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [3:0]  rstrb,
  input  logic [31:0] word,
  output logic [31:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= word & lane_mask(rstrb);
    else            rdata <= '0;
  end
endmodule

// File: rtl/irq_tgt_bank.sv
`timescale 1ns/1ps
module irq_tgt_bank #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_wstrb,
  input  logic        bus_rd,
  input  logic [3:0]  bus_rstrb,
  output logic [31:0] bus_rdata
);
  localparam int NUM_WORDS = NUM_IRQS / 4;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [31:0]      word;

  irq_tgt_decode #(
    .ADDR_W(12), .SPAN_W(10), .BASE(12'h800),
    .NUM_IRQS(NUM_IRQS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  irq_tgt_store #(
    .NUM_CPUS(NUM_CPUS), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && hit), .wstrb(bus_wstrb),
    .wdata(bus_wdata), .idx(idx), .word(word)
  );

  irq_tgt_rdport u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd && hit), .rstrb(bus_rstrb),
    .word(word), .rdata(bus_rdata)
  );
endmodule

// File: rtl/irq_tgt_bank_chk.sv
`timescale 1ns/1ps
module irq_tgt_bank_chk
  import irq_tgt_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_IRQS = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [3:0]  bus_wstrb,
  input logic        bus_rd,
  input logic [3:0]  bus_rstrb,
  input logic [31:0] bus_rdata
);
  localparam logic [31:0] CPU_W = cpu_word(NUM_CPUS);

  logic in_win, past_lim;
  assign in_win   = (bus_addr[11:10] == 2'b10);
  assign past_lim = in_win && (int'(bus_addr[9:0]) >= NUM_IRQS);

  // these pins take no part in any property
  logic unused_ok;
  assign unused_ok = bus_wr ^ (^bus_wdata) ^ (^bus_wstrb);

  assert_no_ghost_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~CPU_W) == 32'h0);

  assert_lane_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_rdata & ~lane_mask($past(bus_rstrb))) == 32'h0);

  assert_past_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && past_lim) |=> bus_rdata == 32'h0);

  assert_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_win) |=> bus_rdata == 32'h0);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'h0);
endmodule

bind irq_tgt_bank irq_tgt_bank_chk #(.NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rd(bus_rd),
  .bus_rstrb(bus_rstrb), .bus_rdata(bus_rdata)
);

// File: tb/irq_tgt_bank_tb.sv
`timescale 1ns/1ps
module irq_tgt_bank_tb;
  localparam int NCPU = 4;
  localparam int NIRQ = 64;
  localparam int NW   = NIRQ / 4;
  localparam logic [7:0] CM = 8'((1 << NCPU) - 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_rstrb = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] model [NW];

  always #10 clk = ~clk;

  irq_tgt_bank #(.NUM_CPUS(NCPU), .NUM_IRQS(NIRQ)) u_dut (.*);

  function automatic bit impl(input logic [11:0] a);
    return (a[11:10] == 2'b10) && (int'(a[9:0]) < NIRQ);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input logic [3:0] rs);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{rs[l]}};
    return impl(a) ? (model[a[9:2]] & m) : 32'h0;
  endfunction

  task automatic model_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    if (impl(a))
      for (int l = 0; l < 4; l++)
        if (s[l]) model[a[9:2]][8*l +: 8] = d[8*l +: 8] & CM;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d, s);
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] rs, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a; bus_rstrb = rs; bus_rd = 1'b1; bus_wr = 1'b0;
    e = exp_rd(a, rs);
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata, e, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    for (int w = 0; w < NW; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int w = 0; w < NW; w++) rd(12'h800 + 12'(4*w), 4'hF, "R1");

    // R2: word store, lane placement
    wr(12'h820, 32'h0103020F, 4'hF);
    rd(12'h820, 4'hF, "R2");
    check(bus_rdata, 32'h0103020F, "R2");
    // R3: ghost processor bits
    wr(12'h824, 32'hFFFFFFFF, 4'hF);
    rd(12'h824, 4'hF, "R3");
    check(bus_rdata, 32'h0F0F0F0F, "R3");
    // R5: single-byte read of interrupt 33
    rd(12'h821, 4'b0010, "R5");
    check(bus_rdata, 32'h00000200, "R5");
    // R4: byte write of interrupt 34 keeps other lanes
    wr(12'h822, 32'h00040000, 4'b0100);
    rd(12'h820, 4'hF, "R4");
    check(bus_rdata, 32'h0104020F, "R4");
    // R8: data gone one cycle later
    @(negedge clk);
    check(bus_rdata, 32'h0, "R8");
    // R6: past the limit, no aliasing onto word 0
    wr(12'h800 + 12'(NIRQ), 32'hFFFFFFFF, 4'hF);
    rd(12'h800 + 12'(NIRQ), 4'hF, "R6");
    rd(12'h800, 4'hF, "R6");
    check(bus_rdata, 32'h0, "R6");
    // R7: outside the window
    wr(12'h400, 32'hFFFFFFFF, 4'hF);
    wr(12'hC00, 32'hFFFFFFFF, 4'hF);
    rd(12'h400, 4'hF, "R7");
    rd(12'h800, 4'hF, "R7");
    rd(12'h820, 4'hF, "R7");
    // R9: read and write on the same word in one cycle
    begin
      logic [31:0] e;
      @(negedge clk);
      bus_addr = 12'h820; bus_wdata = 32'h05050505; bus_wstrb = 4'hF;
      bus_rstrb = 4'hF; bus_wr = 1'b1; bus_rd = 1'b1;
      e = exp_rd(12'h820, 4'hF);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check(bus_rdata, e, "R9");
      model_wr(12'h820, 32'h05050505, 4'hF);
      rd(12'h820, 4'hF, "R9");
    end

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      if ($urandom % 8 == 0) a = 12'($urandom % 4096);
      else a = 12'h800 + 12'($urandom % (NIRQ + 16));
      if ($urandom % 2 == 0) wr(a, $urandom, 4'($urandom));
      else rd(a, 4'($urandom), "R4");
    end
    for (int w = 0; w < NW; w++) rd(12'h800 + 12'(4*w), 4'hF, "R2");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule